// File: doc/BRIEF.md
# Indexed Address Generator with Post-Increment

This block computes the 16-bit effective address of an indexed load or store. The caller gives it a 3-bit register number and the two bytes of the register pair that number belongs to. The odd register of the pair holds the upper address byte and the even register holds the lower byte. The caller can also give an 8-bit displacement and a flag that says whether to add it. The result is registered, so it appears one clock after the request.

The block also produces the pair value plus one and a write-back strobe. When post-increment is enabled at build time and the request names the odd register, the register file writes that incremented value back to the pair after the access. This has the same effect as a plain indexed access followed by a separate 16-bit increment of the pair.

A build-time option selects how the displacement is extended. By default it is extended as a two's-complement value; the other setting extends it with zeros. The loaded byte always goes to register 0. That routing, the memory access and the register file itself belong to the surrounding datapath.

Top module: `iag_indexed_addr`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs `addr_valid`, `addr`, `wb_en`, `wb_value` and `wb_pair` all become zero.
- R2: One cycle after a request (`req_valid`=1), `addr_valid` is 1. `addr` equals the base `{pair_hi, pair_lo}` when `use_offset`=0, and the base plus the extended displacement when `use_offset`=1. `pair_hi` is the odd register's byte.
- R3: With `UNSIGNED_OFS`=0, the displacement is sign-extended: bit 7 set means the value minus 256 is added.
- R4: With `UNSIGNED_OFS`=1, the displacement is zero-extended, giving a value from 0 to 255.
- R5: The address sum and the pair increment both wrap modulo 65536, with no carry out.
- R6: With `AUTO_INC`=1 and `reg_sel[0]`=1, `wb_en` is 1 in the same cycle as `addr_valid`. `wb_pair` equals `reg_sel[2:1]`.
- R7: A request that names an even register (`reg_sel[0]`=0) never raises `wb_en`, even with `AUTO_INC`=1.
- R8: With `AUTO_INC`=0, `wb_en` stays 0. Naming the odd or the even register of a pair gives the same address.
- R9: `wb_value` is the base pair value plus one, not the address plus one, whatever the displacement is.
- R10: One cycle after a cycle with `req_valid`=0, both `addr_valid` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Indexed access request this cycle |
| reg_sel | input | 3 | Register number; bits 2:1 pick the pair, bit 0 picks odd or even |
| pair_lo | input | 8 | Even-register byte (address low) |
| pair_hi | input | 8 | Odd-register byte (address high) |
| offset | input | 8 | Displacement byte |
| use_offset | input | 1 | Add the displacement |
| addr_valid | output | 1 | Registered address is valid |
| addr | output | 16 | Effective address |
| wb_en | output | 1 | Write the incremented pair back |
| wb_value | output | 16 | Pair value plus one |
| wb_pair | output | 2 | Pair index to write back |

## Verification
The bench sweeps every displacement byte against every register number for bases close to the carry and sign boundaries (0x0000, 0x00FF, 0x7FFF, 0x8000, 0xFFFF). It does this on two builds, one with signed displacement and post-increment, the other with unsigned displacement and no post-increment. Each kind of fault shows up in a specific way:
- Wrong extension: negative displacements give addresses 256 too high or too low.
- A carry that escapes or is dropped: addresses near 0xFFFF come out wrong.
- Write-back decoded from the wrong register bit: even-register requests raise the strobe.
- An increment taken from the summed address: `wb_value` is off by the displacement.

// File: rtl/iag_pkg.sv
// Package: shared widths and types of the indexed address generator.
// Assumes an address that is exactly two data bytes wide.
package iag_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/iag_offset_ext.sv
// Extends a displacement to the address width.
// The UNSIGNED_OFS parameter picks zero extension (1) or sign extension (0).
// Assumes OFS_W < ADDR_W.
module iag_offset_ext #(
    parameter int OFS_W        = 8,
    parameter int ADDR_W       = 16,
    parameter bit UNSIGNED_OFS = 1'b0
) (
    input  logic [OFS_W-1:0]  ofs_in,
    output logic [ADDR_W-1:0] ofs_ext
);
    localparam int PAD_W = ADDR_W - OFS_W;

    generate
        if (UNSIGNED_OFS) begin : g_zero
            // Pad with zeros.
            always_comb begin
                ofs_ext = {{PAD_W{1'b0}}, ofs_in};
                a_r4_zero_pad: assert (ofs_ext[ADDR_W-1:OFS_W] == '0);
            end
        end else begin : g_sign
            // Replicate the top displacement bit.
            always_comb begin
                ofs_ext = {{PAD_W{ofs_in[OFS_W-1]}}, ofs_in};
                a_r3_sign_pad: assert (ofs_ext[ADDR_W-1] == ofs_in[OFS_W-1]);
            end
        end
    endgenerate
endmodule

// File: rtl/iag_addr_add.sv
// Adds the extended displacement to the base when enabled.
// Any carry out of the top bit is discarded, so the sum wraps.
module iag_addr_add #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs_ext,
    input  logic              add_en,
    output logic [ADDR_W-1:0] eff_addr
);
    // Select between the plain base and the base plus displacement.
    always_comb begin
        eff_addr = add_en ? (base + ofs_ext) : base;
    end
endmodule

// File: rtl/iag_incr_wb.sv
// Builds the post-increment value and decides whether to write it back.
// Write-back needs AUTO_INC, a live request and an odd register number.
module iag_incr_wb #(
    parameter int ADDR_W   = 16,
    parameter int SEL_W    = 3,
    parameter bit AUTO_INC = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SEL_W-1:0]  sel,
    input  logic              req,
    output logic [ADDR_W-1:0] inc_value,
    output logic              inc_en,
    output logic [SEL_W-2:0]  inc_pair
);
    // Increment the pair (wraps) and decode the write-back strobe.
    always_comb begin
        inc_value = base + {{(ADDR_W-1){1'b0}}, 1'b1};
        inc_en    = AUTO_INC && req && sel[0];
        inc_pair  = sel[SEL_W-1:1];
    end
endmodule

// File: rtl/iag_indexed_addr.sv
// Top: indexed effective-address generator with optional post-increment.
// The base is {pair_hi, pair_lo}, where pair_hi is the odd register's byte.
// All outputs are registered, with one cycle of latency.
// Reset is synchronous and active low.
module iag_indexed_addr
    import iag_pkg::*;
#(
    parameter bit AUTO_INC     = 1'b1,
    parameter bit UNSIGNED_OFS = 1'b0,
    parameter int SEL_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] pair_lo,
    input  logic [BYTE_W-1:0] pair_hi,
    input  logic [BYTE_W-1:0] offset,
    input  logic              use_offset,
    output logic              addr_valid,
    output logic [WORD_W-1:0] addr,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_value,
    output logic [SEL_W-2:0]  wb_pair
);
    word_t             base_w;
    word_t             ofs_w;
    word_t             sum_w;
    word_t             inc_w;
    logic              inc_en_w;
    logic [SEL_W-2:0]  inc_pair_w;

    // Join the two bytes of the pair into the base address.
    always_comb begin
        base_w = {pair_hi, pair_lo};
    end

    iag_offset_ext #(.OFS_W(BYTE_W), .ADDR_W(WORD_W), .UNSIGNED_OFS(UNSIGNED_OFS)) u_ext (
        .ofs_in (offset),
        .ofs_ext(ofs_w)
    );

    iag_addr_add #(.ADDR_W(WORD_W)) u_add (
        .base    (base_w),
        .ofs_ext (ofs_w),
        .add_en  (use_offset),
        .eff_addr(sum_w)
    );

    iag_incr_wb #(.ADDR_W(WORD_W), .SEL_W(SEL_W), .AUTO_INC(AUTO_INC)) u_inc (
        .base     (base_w),
        .sel      (reg_sel),
        .req      (req_valid),
        .inc_value(inc_w),
        .inc_en   (inc_en_w),
        .inc_pair (inc_pair_w)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr       <= '0;
            wb_en      <= 1'b0;
            wb_value   <= '0;
            wb_pair    <= '0;
        end else begin
            addr_valid <= req_valid;
            addr       <= sum_w;
            wb_en      <= inc_en_w;
            wb_value   <= inc_w;
            wb_pair    <= inc_pair_w;
        end
    end

    a_r6_wb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> addr_valid);

    a_r6_odd_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        (AUTO_INC && req_valid && reg_sel[0]) |=> (wb_en && wb_pair == $past(reg_sel[SEL_W-1:1])));

    a_r7_even_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !reg_sel[0]) |=> !wb_en);

    a_r2_plain_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !use_offset) |=> (addr_valid && addr == $past({pair_hi, pair_lo})));

    a_r9_incr_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (wb_value == WORD_W'($past({pair_hi, pair_lo}) + 1'b1)));

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !wb_en));

    generate
        if (!AUTO_INC) begin : g_noinc_chk
            a_r8_no_wb: assert property (@(posedge clk) disable iff (!rst_n) !wb_en);
        end
    endgenerate
endmodule

// File: tb/tb_iag_indexed_addr.sv
module tb_iag_indexed_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  pair_lo = '0;
    logic [7:0]  pair_hi = '0;
    logic [7:0]  offset = '0;
    logic        use_offset = 1'b0;

    logic        av_s, wb_s, av_u, wb_u;
    logic [15:0] ad_s, wv_s, ad_u, wv_u;
    logic [1:0]  wp_s, wp_u;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iag_indexed_addr #(.AUTO_INC(1'b1), .UNSIGNED_OFS(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .reg_sel(reg_sel),
        .pair_lo(pair_lo), .pair_hi(pair_hi), .offset(offset), .use_offset(use_offset),
        .addr_valid(av_s), .addr(ad_s), .wb_en(wb_s), .wb_value(wv_s), .wb_pair(wp_s));

    iag_indexed_addr #(.AUTO_INC(1'b0), .UNSIGNED_OFS(1'b1)) dut_u (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .reg_sel(reg_sel),
        .pair_lo(pair_lo), .pair_hi(pair_hi), .offset(offset), .use_offset(use_offset),
        .addr_valid(av_u), .addr(ad_u), .wb_en(wb_u), .wb_value(wv_u), .wb_pair(wp_u));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] base_pick(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h00FF;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            default: return 16'h1234;
        endcase
    endfunction

    task automatic apply(input logic v, input logic [2:0] s, input logic [15:0] b,
                         input logic [7:0] o, input logic u);
        logic [15:0] ext_s, ext_u, ea_s, ea_u, inc;
        logic [16:0] wide;
        @(negedge clk);
        req_valid = v; reg_sel = s; pair_hi = b[15:8]; pair_lo = b[7:0];
        offset = o; use_offset = u;
        @(posedge clk);
        #1;
        ext_s = {{8{o[7]}}, o};
        ext_u = {8'h00, o};
        ea_s  = u ? 16'(b + ext_s) : b;
        ea_u  = u ? 16'(b + ext_u) : b;
        inc   = 16'(b + 16'd1);
        wide  = {1'b0, b} + {1'b0, ext_u};
        if (!v) begin
            chk(!av_s && !wb_s, "R10 signed build idle", {av_s, wb_s}, 0);
            chk(!av_u && !wb_u, "R10 unsigned build idle", {av_u, wb_u}, 0);
        end else begin
            chk(av_s && ad_s == ea_s,
                !u ? "R2 plain address" : (wide[16] ? "R5 wrap signed sum" : "R3 signed offset"),
                {av_s, ad_s}, {1'b1, ea_s});
            chk(av_u && ad_u == ea_u,
                !u ? "R8 same address either register" : (wide[16] ? "R5 wrap unsigned sum" : "R4 unsigned offset"),
                {av_u, ad_u}, {1'b1, ea_u});
            chk(wb_s == s[0], s[0] ? "R6 odd write-back" : "R7 even no write-back", wb_s, s[0]);
            if (s[0]) chk(wp_s == s[2:1], "R6 pair index", wp_s, s[2:1]);
            chk(wv_s == inc, (b == 16'hFFFF) ? "R5 increment wrap" : "R9 increment from base", wv_s, inc);
            chk(!wb_u, "R8 no write-back when disabled", wb_u, 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset clears all outputs
        req_valid = 1'b1; reg_sel = 3'd5; pair_hi = 8'hAB; pair_lo = 8'hCD; use_offset = 1'b1; offset = 8'h10;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk(!av_s && ad_s == 0 && !wb_s && wv_s == 0 && wp_s == 0, "R1 reset signed build",
            {av_s, wb_s, ad_s}, 0);
        chk(!av_u && ad_u == 0 && !wb_u && wv_u == 0 && wp_u == 0, "R1 reset unsigned build",
            {av_u, wb_u, ad_u}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7 R8 R9: full displacement sweep for each base and register
        for (int bi = 0; bi < 6; bi++)
            for (int s = 0; s < 8; s++)
                for (int o = 0; o < 256; o++)
                    apply(1'b1, 3'(s), base_pick(bi), 8'(o), 1'b1);
        // R2 R8: displacement disabled, displacement byte must not matter
        for (int bi = 0; bi < 6; bi++)
            for (int s = 0; s < 8; s++)
                for (int o = 0; o < 256; o += 51)
                    apply(1'b1, 3'(s), base_pick(bi), 8'(o), 1'b0);
        // R10: idle cycles between requests
        for (int s = 0; s < 8; s++) begin
            apply(1'b0, 3'(s), 16'h4321, 8'h80, 1'b1);
            apply(1'b1, 3'(s), 16'h4321, 8'h80, 1'b1);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule